// File: doc/BRIEF.md
# PCI Base Address Window Decoder

This block watches the address registers of one PCI function (six base address registers and the expansion ROM register) together with the function's command word. From these values it works out, for every region, whether the region is mapped right now and at which aligned base. It keeps that result in registers and then matches incoming I/O or memory addresses against the mapped windows. Each region's size and its kind (I/O or memory) are fixed by parameters. A size of zero marks a region that is not built.

Some register values are degenerate and leave the window closed: a zero base, a window that wraps, an I/O window that reaches past 64 KiB, or a memory window that ends on the top address. The ROM window also stays closed until its own enable bit is set. When a window moves, the block first sends a one-cycle unmap pulse for the old window and, on the next clock, a one-cycle map pulse for the new one. Downstream address-space logic therefore always sees a teardown before a setup.

The address lookup is a pure combinational lookup from the registered windows. It takes one access qualifier (`acc_valid`) and has no ready signal, because the block can never stall or refuse a lookup: each access is answered in the same cycle. All other pins are plain control and status levels.

Top module: `bar_window_decoder`

## Requirements
- R1: A region's effective base is its raw register value ANDed with the complement of (size − 1). The block holds this base in a register and reports it on `region_base` (32 bits per region, region i at bits i*32 and up, ROM at index 6) while `region_valid` is high, and reports zero while the region is unmapped. A closed region that becomes mappable shows valid and base one clock edge after the inputs change.
- R2: An I/O region is mapped only while command bit 0 is 1. A memory region or the ROM is mapped only while command bit 1 is 1.
- R3: The ROM region (index 6) is mapped only while bit 0 of the ROM register is 1.
- R4: An I/O region is unmapped when its base is zero, when base + size − 1 is not above the base, or when its last address is 0x10000 or higher.
- R5: A memory or ROM region is unmapped when its base is zero, when its window wraps, or when its last address is 0xFFFFFFFF.
- R6: A region whose size parameter is zero never reports valid, never pulses and never hits.
- R7: When a mapped region's base changes or the region becomes unmappable, `unmap_pulse` is high for exactly one cycle and valid drops in that same cycle. If the new window is valid, `map_pulse` follows on the next cycle together with the new base. Map and unmap are never high together for one region.
- R8: `hit_vec` bit i is high in the same cycle when `acc_valid` is 1, region i is valid, `acc_is_io` matches the region's kind (1 = I/O; the ROM counts as memory), and `acc_addr` lies in [base, base + size − 1].
- R9: While reset is asserted and right after it, all valid flags, bases and pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 16 | Command word; bit 0 enables I/O, bit 1 enables memory |
| bar_raw | input | 192 | Six raw 32-bit base registers, register i at bits i*32 |
| rom_raw | input | 32 | Raw expansion ROM register, bit 0 is the ROM enable |
| acc_valid | input | 1 | Incoming access present |
| acc_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| acc_addr | input | 32 | Access address |
| hit_vec | output | 7 | Per-region hit, ROM at bit 6 |
| region_valid | output | 7 | Per-region mapped flag |
| region_base | output | 224 | Per-region aligned base, zero while unmapped |
| map_pulse | output | 7 | One-cycle pulse when a window is set up |
| unmap_pulse | output | 7 | One-cycle pulse when a window is torn down |

## Verification
The hardest case to reach from the ports is a region that is already mapped moving to a new base that is also valid. Only this case produces the unmap-then-map pair on back-to-back cycles. Random register values almost never give a valid I/O window or a memory window that ends exactly on the top address. The stimulus therefore draws each register from a few classes: fully random, confined below 64 KiB, zero, and the topmost aligned block. Directed steps then move a mapped memory window and check the pulse order cycle by cycle.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int          ADDR_W     = 32;
  localparam logic [31:0] IO_LIMIT   = 32'h0001_0000;
  localparam int          CMD_IO_BIT = 0;
  localparam int          CMD_MEM_BIT = 1;
  localparam int          ROM_EN_BIT = 0;

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] base;
  } win_t;
endpackage

// File: rtl/bwd_region_eval.sv
module bwd_region_eval
  import bwd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SIZE   = 32'h100,
  parameter bit                IS_IO  = 1'b0,
  parameter bit                IS_ROM = 1'b0
) (
  input  logic [1:0]        cmd_en,
  input  logic [ADDR_W-1:0] raw,
  output win_t              cand
);
  localparam logic [ADDR_W-1:0] MASK = ~(SIZE - 32'd1);

  logic [ADDR_W-1:0] base_c, last_c;
  logic              en_c, ok_c;

  always_comb begin
    base_c = raw & MASK;
    last_c = base_c + SIZE - 32'd1;
    en_c   = IS_IO ? cmd_en[CMD_IO_BIT] : cmd_en[CMD_MEM_BIT];
    if (IS_ROM) en_c = en_c & raw[ROM_EN_BIT];
    if (SIZE == '0) begin
      ok_c = 1'b0;
    end else if (IS_IO) begin
      ok_c = en_c && (base_c != '0) && (last_c > base_c) && (last_c < IO_LIMIT);
    end else begin
      ok_c = en_c && (base_c != '0) && (last_c > base_c) && (last_c != '1);
    end
    cand.valid = ok_c;
    cand.base  = base_c;
  end
endmodule

// File: rtl/bwd_region_track.sv
module bwd_region_track
  import bwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  win_t              cand,
  output logic              valid_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              map_o,
  output logic              unmap_o
);
  logic              v_q;
  logic [ADDR_W-1:0] b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      b_q     <= '0;
      map_o   <= 1'b0;
      unmap_o <= 1'b0;
    end else begin
      map_o   <= 1'b0;
      unmap_o <= 1'b0;
      if (v_q && (!cand.valid || cand.base != b_q)) begin
        v_q     <= 1'b0;
        unmap_o <= 1'b1;
      end else if (!v_q && cand.valid) begin
        v_q   <= 1'b1;
        b_q   <= cand.base;
        map_o <= 1'b1;
      end
    end
  end

  assign valid_o = v_q;
  assign base_o  = v_q ? b_q : '0;

  // R7: pulses are exclusive and tied to the valid edges
  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(map_o && unmap_o));
  p_map_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    map_o |-> (v_q && !$past(v_q)));
  p_unmap_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unmap_o |-> (!v_q && $past(v_q)));
  // R1: a mapped window keeps its base until it is torn down
  p_base_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && $past(v_q)) |-> $stable(b_q));
endmodule

// File: rtl/bwd_hit_decode.sv
module bwd_hit_decode
  import bwd_pkg::*;
#(
  parameter int                       NREG    = 7,
  parameter logic [NREG*ADDR_W-1:0]   SIZES   = '0,
  parameter logic [NREG-1:0]          IO_KIND = '0
) (
  input  logic                     acc_valid,
  input  logic                     acc_is_io,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [NREG-1:0]          reg_valid,
  input  logic [NREG*ADDR_W-1:0]   reg_base,
  output logic [NREG-1:0]          hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] SZ = SIZES[i*ADDR_W +: ADDR_W];
    if (SZ == '0) begin : g_none
      assign hit[i] = 1'b0;
    end else begin : g_cmp
      logic [ADDR_W-1:0] lo, hi;
      assign lo     = reg_base[i*ADDR_W +: ADDR_W];
      assign hi     = lo + SZ - 32'd1;
      assign hit[i] = acc_valid && reg_valid[i] && (acc_is_io == IO_KIND[i]) &&
                      (acc_addr >= lo) && (acc_addr <= hi);
    end
  end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import bwd_pkg::*;
#(
  parameter int NUM_BAR = 6,
  parameter logic [(NUM_BAR+1)*32-1:0] REGION_SIZES =
    {32'h0001_0000, 32'h0, 32'h20, 32'h0, 32'h0010_0000, 32'h1000, 32'h100},
  parameter logic [NUM_BAR-1:0] BAR_IS_IO = 6'b010001
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [15:0]                  cmd_word,
  input  logic [NUM_BAR*ADDR_W-1:0]    bar_raw,
  input  logic [ADDR_W-1:0]            rom_raw,
  input  logic                         acc_valid,
  input  logic                         acc_is_io,
  input  logic [ADDR_W-1:0]            acc_addr,
  output logic [NUM_BAR:0]             hit_vec,
  output logic [NUM_BAR:0]             region_valid,
  output logic [(NUM_BAR+1)*ADDR_W-1:0] region_base,
  output logic [NUM_BAR:0]             map_pulse,
  output logic [NUM_BAR:0]             unmap_pulse
);
  localparam int NREG = NUM_BAR + 1;
  localparam logic [NREG-1:0] KIND = {1'b0, BAR_IS_IO};

  logic [1:0] cmd_en;
  logic       unused_cmd;
  assign cmd_en     = {cmd_word[CMD_MEM_BIT], cmd_word[CMD_IO_BIT]};
  assign unused_cmd = ^cmd_word[15:2];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] SZ = REGION_SIZES[i*ADDR_W +: ADDR_W];
    localparam bit ROM = (i == NUM_BAR);
    logic [ADDR_W-1:0] raw;
    win_t              cand;

    if (ROM) begin : g_rom_src
      assign raw = rom_raw;
    end else begin : g_bar_src
      assign raw = bar_raw[i*ADDR_W +: ADDR_W];
    end

    bwd_region_eval #(.SIZE(SZ), .IS_IO(KIND[i]), .IS_ROM(ROM)) u_eval (
      .cmd_en (cmd_en),
      .raw    (raw),
      .cand   (cand)
    );

    bwd_region_track u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .cand    (cand),
      .valid_o (region_valid[i]),
      .base_o  (region_base[i*ADDR_W +: ADDR_W]),
      .map_o   (map_pulse[i]),
      .unmap_o (unmap_pulse[i])
    );

    // R8: a hit never comes from a closed window
    p_hit_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[i] |-> region_valid[i]);

    if (SZ == '0) begin : g_chk_none
      // R6: an unbuilt region stays silent
      p_unbuilt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(region_valid[i] || map_pulse[i] || unmap_pulse[i]));
    end else if (KIND[i]) begin : g_chk_io
      // R4: a mapped I/O window ends below 64 KiB
      p_io_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        region_valid[i] |-> ((region_base[i*ADDR_W +: ADDR_W] + SZ - 32'd1) < IO_LIMIT));
    end else begin : g_chk_mem
      // R5: a mapped memory window never ends on the top address
      p_mem_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        region_valid[i] |-> ((region_base[i*ADDR_W +: ADDR_W] + SZ - 32'd1) != '1));
    end
  end

  bwd_hit_decode #(.NREG(NREG), .SIZES(REGION_SIZES), .IO_KIND(KIND)) u_hit (
    .acc_valid (acc_valid),
    .acc_is_io (acc_is_io),
    .acc_addr  (acc_addr),
    .reg_valid (region_valid),
    .reg_base  (region_base),
    .hit       (hit_vec)
  );

  // R9: nothing is mapped on the first cycle out of reset
  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |=> (region_valid == '0 && map_pulse == '0 && unmap_pulse == '0));
endmodule

// File: tb/bar_window_decoder_tb_top.sv
module bar_window_decoder_tb_top;
  localparam int NB = 6;
  localparam int NR = 7;
  localparam logic [NR*32-1:0] SZS =
    {32'h0001_0000, 32'h0, 32'h20, 32'h0, 32'h0010_0000, 32'h1000, 32'h100};
  localparam logic [NB-1:0] IOM = 6'b010001;
  localparam logic [NR-1:0] KIND = {1'b0, IOM};

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [15:0] cmd_word = '0;
  logic [NB*32-1:0] bar_raw = '0;
  logic [31:0] rom_raw = '0;
  logic acc_valid = 1'b0, acc_is_io = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [NR-1:0] hit_vec, region_valid, map_pulse, unmap_pulse;
  logic [NR*32-1:0] region_base;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  bar_window_decoder #(.NUM_BAR(NB), .REGION_SIZES(SZS), .BAR_IS_IO(IOM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .bar_raw(bar_raw),
    .rom_raw(rom_raw), .acc_valid(acc_valid), .acc_is_io(acc_is_io),
    .acc_addr(acc_addr), .hit_vec(hit_vec), .region_valid(region_valid),
    .region_base(region_base), .map_pulse(map_pulse), .unmap_pulse(unmap_pulse)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] raw_of(input int i);
    return (i < NB) ? bar_raw[i*32 +: 32] : rom_raw;
  endfunction

  // expected {valid, reported base} from the requirements R1-R6 rules
  function automatic logic [32:0] model(input int i, input logic [15:0] c, input logic [31:0] raw);
    logic [31:0] sz, b, l;
    logic ok;
    sz = SZS[i*32 +: 32];
    if (sz == 0) return 33'd0;
    b = raw & ~(sz - 32'd1);
    l = b + sz - 32'd1;
    if (KIND[i]) ok = c[0] && b != 0 && l > b && l < 32'h10000;
    else ok = c[1] && (i != NB || raw[0]) && b != 0 && l > b && l != 32'hFFFF_FFFF;
    return {ok, ok ? b : 32'h0};
  endfunction

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NR; i++) begin
      logic [32:0] e;
      e = model(i, cmd_word, raw_of(i));
      chk(region_valid[i] == e[32], {req, " valid"}, region_valid[i], e[32]);
      chk(region_base[i*32 +: 32] == e[31:0], {req, " base"}, region_base[i*32 +: 32], e[31:0]);
    end
    chk(map_pulse == 0 && unmap_pulse == 0, {req, " quiet pulses R7"}, {map_pulse, unmap_pulse}, 0);
  endtask

  task automatic check_hit(input logic v, input logic io, input logic [31:0] a, input string req);
    logic [NR-1:0] e;
    acc_valid = v; acc_is_io = io; acc_addr = a;
    #1;
    e = '0;
    for (int i = 0; i < NR; i++) begin
      logic [32:0] m;
      logic [31:0] sz;
      m  = model(i, cmd_word, raw_of(i));
      sz = SZS[i*32 +: 32];
      if (v && m[32] && io == KIND[i] && a >= m[31:0] && a <= m[31:0] + sz - 32'd1) e[i] = 1'b1;
    end
    chk(hit_vec == e, req, hit_vec, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 rst_n = 1'b0;
    cmd_word = 16'h0003;
    bar_raw[0*32 +: 32] = 32'h0000_1000;
    rom_raw = 32'h000C_0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: held in reset, nothing mapped
    chk(region_valid == 0 && map_pulse == 0 && unmap_pulse == 0 && region_base == 0,
        "R9 reset state", {region_valid, map_pulse}, 0);
    bar_raw = '0; rom_raw = '0; cmd_word = 16'h0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(region_valid == 0, "R9 after reset", region_valid, 0);

    // R2: enables
    bar_raw[0*32 +: 32] = 32'h0000_1000;
    bar_raw[1*32 +: 32] = 32'h4000_0000;
    bar_raw[2*32 +: 32] = 32'h8000_0000;
    bar_raw[3*32 +: 32] = 32'h1234_5678;
    bar_raw[4*32 +: 32] = 32'h0000_2024;
    rom_raw = 32'h000C_0001;
    settle(); check_all("R2 cmd off");
    chk(region_valid == 0, "R2 nothing mapped with enables off", region_valid, 0);
    cmd_word = 16'h0001; settle(); check_all("R2 io only");
    chk(region_valid == 7'b0010001, "R2 io only set", region_valid, 7'b0010001);
    chk(region_base[4*32 +: 32] == 32'h2020, "R1 aligned io base", region_base[4*32 +: 32], 32'h2020);
    cmd_word = 16'h0002; settle(); check_all("R2 mem only");
    chk(region_valid == 7'b1000110, "R2 mem only set", region_valid, 7'b1000110);
    cmd_word = 16'hFFFF; settle(); check_all("R2 all on");

    // R3: ROM enable bit
    rom_raw = 32'h000C_0000; settle();
    chk(region_valid[6] == 1'b0, "R3 rom bit0 clear", region_valid[6], 0);
    rom_raw = 32'h000C_0001; settle();
    chk(region_valid[6] && region_base[6*32 +: 32] == 32'h000C_0000, "R3 rom enabled",
        region_base[6*32 +: 32], 32'h000C_0000);

    // R4: I/O limits
    bar_raw[0*32 +: 32] = 32'h0000_FF00; settle();
    chk(region_valid[0] && region_base[31:0] == 32'hFF00, "R4 io top block", region_base[31:0], 32'hFF00);
    bar_raw[0*32 +: 32] = 32'h0001_0000; settle();
    chk(!region_valid[0], "R4 io past 64K", region_valid[0], 0);
    bar_raw[0*32 +: 32] = 32'h0000_00AB; settle();
    chk(!region_valid[0], "R4 io zero base", region_valid[0], 0);

    // R5: memory limits
    bar_raw[1*32 +: 32] = 32'hFFFF_F000; settle();
    chk(!region_valid[1], "R5 mem ends at top", region_valid[1], 0);
    bar_raw[1*32 +: 32] = 32'hFFFF_E000; settle();
    chk(region_valid[1], "R5 mem below top", region_valid[1], 1);
    bar_raw[1*32 +: 32] = 32'h0000_0FFF; settle();
    chk(!region_valid[1], "R5 mem zero base", region_valid[1], 0);

    // R6: unbuilt region
    check_hit(1'b1, 1'b0, 32'h1234_5678, "R6 no hit on unbuilt region");
    chk(!region_valid[3] && !region_valid[5], "R6 unbuilt never valid", {region_valid[3], region_valid[5]}, 0);

    // R7: first map, then remap order cycle by cycle
    bar_raw[1*32 +: 32] = 32'h4000_0000;
    @(posedge clk); @(negedge clk);
    chk(map_pulse[1] && !unmap_pulse[1] && region_valid[1], "R7 first map one edge", {map_pulse[1], region_valid[1]}, 2'b11);
    chk(region_base[1*32 +: 32] == 32'h4000_0000, "R1 base after one edge", region_base[1*32 +: 32], 32'h4000_0000);
    @(posedge clk); @(negedge clk);
    chk(!map_pulse[1], "R7 map pulse single cycle", map_pulse[1], 0);
    bar_raw[1*32 +: 32] = 32'h5000_0123;
    @(posedge clk); @(negedge clk);
    chk(unmap_pulse[1] && !map_pulse[1] && !region_valid[1], "R7 unmap first",
        {unmap_pulse[1], map_pulse[1], region_valid[1]}, 3'b100);
    @(posedge clk); @(negedge clk);
    chk(map_pulse[1] && !unmap_pulse[1] && region_valid[1] && region_base[1*32 +: 32] == 32'h5000_0000,
        "R7 map second", region_base[1*32 +: 32], 32'h5000_0000);
    @(posedge clk); @(negedge clk);
    chk(!map_pulse[1] && !unmap_pulse[1], "R7 quiet after remap", {map_pulse[1], unmap_pulse[1]}, 0);
    cmd_word = 16'h0001;
    @(posedge clk); @(negedge clk);
    chk(unmap_pulse[1] && !region_valid[1], "R7 unmap on disable", unmap_pulse[1], 1);
    @(posedge clk); @(negedge clk);
    chk(!map_pulse[1] && !unmap_pulse[1], "R7 no map when closed", {map_pulse[1], unmap_pulse[1]}, 0);
    cmd_word = 16'h0003; settle();

    // R8: hit edges
    check_hit(1'b1, 1'b0, 32'h5000_0000, "R8 hit at base");
    check_hit(1'b1, 1'b0, 32'h5000_0FFF, "R8 hit at last");
    check_hit(1'b1, 1'b0, 32'h5000_1000, "R8 miss past last");
    check_hit(1'b1, 1'b0, 32'h4FFF_FFFF, "R8 miss below base");
    check_hit(1'b1, 1'b1, 32'h5000_0010, "R8 wrong kind");
    check_hit(1'b0, 1'b0, 32'h5000_0010, "R8 no access");
    check_hit(1'b1, 1'b0, 32'h000C_8000, "R8 rom hit");

    // random mix R1-R8
    for (int n = 0; n < 300; n++) begin
      cmd_word = ($urandom % 5 == 0) ? 16'($urandom) : 16'h0003;
      for (int i = 0; i < NR; i++) begin
        logic [31:0] r, sz;
        sz = SZS[i*32 +: 32];
        case ($urandom % 4)
          0: r = $urandom;
          1: r = $urandom % 32'h10000;
          2: r = 32'h0;
          default: r = ~(sz - 32'd1) | ($urandom % 2);
        endcase
        if (i < NB) bar_raw[i*32 +: 32] = r; else rom_raw = r;
      end
      settle();
      check_all("R1 R4 R5 random");
      for (int k = 0; k < 4; k++) begin
        int ri;
        logic [32:0] m;
        logic [31:0] a, sz;
        ri = int'($urandom % NR);
        m  = model(ri, cmd_word, raw_of(ri));
        sz = SZS[ri*32 +: 32];
        if (m[32] && sz != 0) a = m[31:0] + ($urandom % sz);
        else a = $urandom;
        check_hit(1'b1, ($urandom % 3 == 0) ? ~KIND[ri] : KIND[ri], a, "R8 random hit");
      end
      acc_valid = 1'b0;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule